// File: doc/BRIEF.md
# Bitfield Move and Extract Unit

This block performs the 64-bit bitfield-move family and the two-register extract on behalf of an execution pipeline. A request carries an operation select, a rotate amount, a top-bit index, two source words and the current destination word. The unit rotates the first source right, builds a field mask from the two immediates, and then either inserts the field into the destination, returns it zero-filled, returns it with the sign bit copied upward, or, for extract, returns a 64-bit window of the concatenation of both sources.

One mask builder serves every bitfield operation. When the rotate amount is at most the top index, the mask is a plain run of low ones. When the rotate amount is larger, the mask is a run of low ones that has itself been rotated right, so the field wraps around the word. The result is registered and a valid strobe follows each request by one clock.

Top module: `bfx_unit`

## Requirements
- R1: When `rot_imm <= top_imm`, the mask is `top_imm - rot_imm + 1` ones starting at bit 0, and the span is `top_imm - rot_imm`.
- R2: When `rot_imm > top_imm`, the mask is `top_imm + 1` low ones rotated right by `rot_imm`, and the span is `top_imm - rot_imm + 64`.
- R3: For the bitfield operations the field is `src_a` rotated right by `rot_imm` (a rotate of zero leaves it unchanged), ANDed with the mask.
- R4: Insert (`op` = 2'b00) returns the field in masked bits and `dst_in` in every bit outside the mask.
- R5: Unsigned extract (`op` = 2'b10) returns the field with every bit outside the mask cleared.
- R6: Signed extract (`op` = 2'b01) returns the field ORed with ones in every bit position above the span when `src_a[top_imm]` is 1, and the field alone otherwise.
- R7: Extract (`op` = 2'b11) with `rot_imm` = 0 returns `src_b` unchanged.
- R8: Extract with `rot_imm` = n > 0 returns `(src_a << (64 - n)) | (src_b >> n)`.
- R9: `res_vld` is high in exactly the cycle after each cycle in which `req` is high, and `res` carries that request's result in that cycle.
- R10: `res` holds its value in cycles that follow a cycle without `req`.
- R11: Synchronous active-high `rst` clears `res_vld` and `res` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one operation per high cycle |
| op | input | 2 | 00 insert, 01 signed, 10 unsigned, 11 extract |
| rot_imm | input | 6 | Rotate amount (extract: shift count) |
| top_imm | input | 6 | Top-bit index of the field |
| src_a | input | 64 | First source word |
| src_b | input | 64 | Second source word (extract only) |
| dst_in | input | 64 | Current destination word (insert only) |
| res | output | 64 | Registered result |
| res_vld | output | 1 | Result valid, one cycle after `req` |

## Verification
The bench aims at the boundary between the direct and wrapped mask, with rotate equal to top, rotate one above top and rotate 63 with top 0; a builder that picks the wrong branch there returns a field of the wrong length or position. Signed cases are run with the sign bit set and clear in both mask shapes, since a design that fills in the wrapped case or ignores the span would set high bits that must stay zero. Extract is driven with counts 0, 1 and 63, where a naive shift by the full width would drop `src_b` or smear `src_a`, and insert is driven with a dense destination so that any lost outside bit shows up. Back-to-back requests, idle gaps and a late reset check that results neither slip a cycle nor change while idle.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    OP_INSERT   = 2'b00,
    OP_SIGNED   = 2'b01,
    OP_UNSIGNED = 2'b10,
    OP_EXTRACT  = 2'b11
  } bfx_op_e;
endpackage

// File: rtl/bfx_rotr.sv
module bfx_rotr #(
  parameter int W  = bfx_pkg::DATA_W,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] amt,
  output logic [W-1:0]  dout
);
  // each output bit picks the source bit amt places above it, modulo W
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [IW-1:0] sel;
    assign sel     = IW'(g) + amt;
    assign dout[g] = din[sel];
  end
endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
  parameter int W  = bfx_pkg::DATA_W,
  parameter int IW = $clog2(W),
  localparam int SW = IW + 1
) (
  input  logic [IW-1:0] rot,
  input  logic [IW-1:0] top,
  output logic [W-1:0]  mask,
  output logic [SW-1:0] span,
  output logic          wrapped
);
  function automatic logic [W-1:0] low_ones(input logic [SW-1:0] n);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < int'(n));
    return r;
  endfunction

  logic [SW-1:0] len_direct;
  logic [SW-1:0] len_wrap;
  logic [W-1:0]  run_direct;
  logic [W-1:0]  run_wrap;
  logic [W-1:0]  run_wrap_rot;

  assign wrapped    = (rot > top);
  assign len_direct = SW'(top) - SW'(rot) + SW'(1);
  assign len_wrap   = SW'(top) + SW'(1);
  assign run_direct = low_ones(len_direct);
  assign run_wrap   = low_ones(len_wrap);

  bfx_rotr #(.W(W), .IW(IW)) i_wrap_rot (
    .din  (run_wrap),
    .amt  (rot),
    .dout (run_wrap_rot)
  );

  assign mask = wrapped ? run_wrap_rot : run_direct;
  // modulo-2^SW arithmetic: adding W in the wrapped case lands on top-rot+W
  assign span = SW'(top) - SW'(rot) + (wrapped ? SW'(W) : SW'(0));
endmodule

// File: rtl/bfx_merge.sv
module bfx_merge #(
  parameter int W  = bfx_pkg::DATA_W,
  parameter int IW = $clog2(W),
  localparam int SW = IW + 1
) (
  input  bfx_pkg::bfx_op_e op,
  input  logic [W-1:0]     rot_src,
  input  logic [W-1:0]     mask,
  input  logic [SW-1:0]    span,
  input  logic             sign_bit,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [IW-1:0]    shamt,
  output logic [W-1:0]     result
);
  import bfx_pkg::*;

  function automatic logic [W-1:0] fill_above(input logic [SW-1:0] s, input logic en);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = en && (i > int'(s));
    return r;
  endfunction

  function automatic logic [W-1:0] cat_window(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                              input logic [IW-1:0] n);
    logic [2*W-1:0] c;
    c = {hi, lo} >> n;
    return c[W-1:0];
  endfunction

  logic [W-1:0] field;
  logic [W-1:0] sfill;
  logic [W-1:0] ext_val;

  assign field   = rot_src & mask;
  assign sfill   = fill_above(span, sign_bit);
  assign ext_val = (shamt == '0) ? src_b : cat_window(src_a, src_b, shamt);

  always_comb begin
    unique case (op)
      OP_INSERT:   result = field | (dst & ~mask);
      OP_SIGNED:   result = field | sfill;
      OP_UNSIGNED: result = field;
      OP_EXTRACT:  result = ext_val;
      default:     result = field;
    endcase
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int W  = bfx_pkg::DATA_W,
  parameter int IW = $clog2(W),
  localparam int SW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [IW-1:0] rot_imm,
  input  logic [IW-1:0] top_imm,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [W-1:0]  dst_in,
  output logic [W-1:0]  res,
  output logic          res_vld
);
  import bfx_pkg::*;

  bfx_op_e       op_e;
  logic [W-1:0]  rot_src;
  logic [W-1:0]  fld_mask;
  logic [SW-1:0] fld_span;
  logic          is_wrap;
  logic [W-1:0]  res_next;

  assign op_e = bfx_op_e'(op);

  bfx_rotr #(.W(W), .IW(IW)) i_src_rot (
    .din  (src_a),
    .amt  (rot_imm),
    .dout (rot_src)
  );

  bfx_mask_gen #(.W(W), .IW(IW)) i_mask (
    .rot     (rot_imm),
    .top     (top_imm),
    .mask    (fld_mask),
    .span    (fld_span),
    .wrapped (is_wrap)
  );

  bfx_merge #(.W(W), .IW(IW)) i_merge (
    .op       (op_e),
    .rot_src  (rot_src),
    .mask     (fld_mask),
    .span     (fld_span),
    .sign_bit (src_a[top_imm]),
    .dst      (dst_in),
    .src_a    (src_a),
    .src_b    (src_b),
    .shamt    (rot_imm),
    .result   (res_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= req;
      if (req) res <= res_next;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int W  = bfx_pkg::DATA_W,
  parameter int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic [1:0]    op,
  input logic [IW-1:0] rot_imm,
  input logic [IW-1:0] top_imm,
  input logic [W-1:0]  src_b,
  input logic [W-1:0]  dst_in,
  input logic [W-1:0]  res,
  input logic          res_vld,
  input logic [W-1:0]  mask_w,
  input logic          wrapped_w
);
  a_r1_direct_count: assert property (@(posedge clk) disable iff (rst)
    !wrapped_w |-> ($countones(mask_w) == int'(top_imm) - int'(rot_imm) + 1) && mask_w[0]);

  a_r2_wrap_count: assert property (@(posedge clk) disable iff (rst)
    wrapped_w |-> ($countones(mask_w) == int'(top_imm) + 1) && !mask_w[0]);

  a_r4_ins_keeps_outside: assert property (@(posedge clk) disable iff (rst)
    (req && op == 2'b00) |=> (((res ^ $past(dst_in)) & ~$past(mask_w)) == '0));

  a_r5_uns_zero_outside: assert property (@(posedge clk) disable iff (rst)
    (req && op == 2'b10) |=> ((res & ~$past(mask_w)) == '0));

  a_r7_ext_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (req && op == 2'b11 && rot_imm == '0) |=> (res == $past(src_b)));

  a_r9_vld_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> res_vld);

  a_r9_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
    !req |=> !res_vld);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(res));
endmodule

bind bfx_unit bfx_unit_chk #(.W(W), .IW(IW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .op        (op),
  .rot_imm   (rot_imm),
  .top_imm   (top_imm),
  .src_b     (src_b),
  .dst_in    (dst_in),
  .res       (res),
  .res_vld   (res_vld),
  .mask_w    (fld_mask),
  .wrapped_w (is_wrap)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = '0;
  logic [5:0]  rot_imm = '0;
  logic [5:0]  top_imm = '0;
  logic [63:0] src_a = '0, src_b = '0, dst_in = '0;
  logic [63:0] res;
  logic        res_vld;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_res = '0;

  always #4 clk = ~clk;  // 125 MHz

  bfx_unit i_bfx_unit (
    .clk(clk), .rst(rst), .req(req), .op(op), .rot_imm(rot_imm), .top_imm(top_imm),
    .src_a(src_a), .src_b(src_b), .dst_in(dst_in), .res(res), .res_vld(res_vld)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent model, bit by bit
  function automatic logic [63:0] model(input logic [1:0] o, input int r, input int t,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] d);
    logic [63:0] rs, m, f, fill;
    logic [127:0] c;
    int span;
    for (int i = 0; i < 64; i++) rs[i] = a[(i + r) % 64];
    m = '0;
    if (r <= t) begin
      for (int i = 0; i < 64; i++) m[i] = (i <= t - r);
      span = t - r;
    end else begin
      for (int j = 0; j <= t; j++) m[(j - r + 64) % 64] = 1'b1;
      span = t - r + 64;
    end
    f = rs & m;
    fill = '0;
    for (int i = 0; i < 64; i++) if (a[t] && i > span) fill[i] = 1'b1;
    case (o)
      2'b00: return f | (d & ~m);
      2'b01: return f | fill;
      2'b10: return f;
      default: begin
        if (r == 0) return b;
        c = {a, b};
        c = c >> r;
        return c[63:0];
      end
    endcase
  endfunction

  task automatic issue(input logic [1:0] o, input int r, input int t,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    string tg;
    @(negedge clk);
    req = 1'b1; op = o; rot_imm = 6'(r); top_imm = 6'(t);
    src_a = a; src_b = b; dst_in = d;
    case (o)
      2'b00: tg = "R4";
      2'b01: tg = "R6";
      2'b10: tg = "R5";
      default: tg = (r == 0) ? "R7" : "R8";
    endcase
    if (o != 2'b11) begin
      tg = {tg, (r <= t) ? " R1" : " R2"};
      if (r == 0) tg = {tg, " R3"};
    end
    exp_q.push_back(model(o, r, t, a, b, d));
    tag_q.push_back({tg, " R9"});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req = 1'b0;
      src_a = {$urandom, $urandom}; dst_in = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected valid act=%h exp=none", res);
      end else begin
        check(tag_q.pop_front(), res, exp_q.pop_front());
        last_res = res;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset vld", 64'(res_vld), 64'd0);
    check("R11 reset res", res, 64'd0);
    rst = 1'b0;

    // insert, direct and wrapped
    issue(2'b00, 8, 15, 64'h0123_4567_89ab_cdef, 64'h0, 64'hffff_ffff_ffff_ffff);
    issue(2'b00, 0, 63, 64'hdead_beef_0bad_f00d, 64'h0, 64'h5555_5555_5555_5555);
    issue(2'b00, 60, 3, 64'h0000_0000_0000_000a, 64'h0, 64'hffff_ffff_ffff_ffff);
    issue(2'b00, 5, 5, 64'h0000_0000_0000_0020, 64'h0, 64'h0);
    // unsigned
    issue(2'b10, 4, 11, 64'hffff_ffff_ffff_fabc, 64'h0, 64'hffff);
    issue(2'b10, 6, 5, 64'hffff_ffff_ffff_ffff, 64'h0, 64'h0);
    issue(2'b10, 63, 0, 64'h1, 64'h0, 64'h0);
    // signed, sign bit set and clear, direct and wrapped
    issue(2'b01, 0, 7, 64'h0000_0000_0000_0080, 64'h0, 64'h0);
    issue(2'b01, 0, 7, 64'h0000_0000_0000_007f, 64'h0, 64'h0);
    issue(2'b01, 8, 15, 64'h0000_0000_0000_8100, 64'h0, 64'h0);
    issue(2'b01, 40, 7, 64'h0000_0000_0000_00ff, 64'h0, 64'h0);
    issue(2'b01, 0, 0, 64'h1, 64'h0, 64'h0);
    // extract
    issue(2'b11, 0, 0, 64'haaaa_aaaa_aaaa_aaaa, 64'h1234_5678_9abc_def0, 64'h0);
    issue(2'b11, 1, 0, 64'h1, 64'h8000_0000_0000_0002, 64'h0);
    issue(2'b11, 63, 9, 64'h8000_0000_0000_0001, 64'hffff_0000_ffff_0000, 64'h0);
    issue(2'b11, 32, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0);
    idle(4);
    check("R10 hold after idle", res, last_res);
    check("R9 no valid while idle", 64'(res_vld), 64'd0);

    // random sweep with gaps
    for (int k = 0; k < 300; k++) begin
      issue(2'($urandom), int'($urandom % 64), int'($urandom % 64),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      if (k % 7 == 0) idle(2);
    end
    idle(3);
    check("R10 hold after sweep", res, last_res);

    // late reset clears a live result
    issue(2'b10, 0, 63, 64'hffff_ffff_ffff_ffff, 64'h0, 64'h0);
    idle(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R11 late reset res", res, 64'd0);
    check("R11 late reset vld", 64'(res_vld), 64'd0);
    rst = 1'b0;
    idle(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 missing results act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule